// File: doc/BRIEF.md
# Multiple Register Block Transfer Sequencer

This block carries out a load-multiple or store-multiple operation between a 16-entry register file and a word-addressed memory. A one-cycle start pulse supplies the direction, the index of the base register and a 16-bit selection mask. The sequencer visits the selected registers from the lowest index to the highest. For each one it drives the register-file ports and makes one memory access through a request/ready handshake. When the last access is done it writes the updated base register back and signals completion.

The register file is outside the block. Its read port is combinational and its write port takes effect at the next clock edge. Two unusual cases behave in fixed ways. An all-zero mask moves only the program counter, but the base is advanced as if all sixteen registers had been listed. A base register that is stored after some other register has already been stored carries its already-advanced value. A load that reaches the program counter ends with a single-cycle pipeline-flush pulse.

Top module: `blkxfer_seq`

## Requirements
- R1: The selected registers are transferred in ascending index order. The first access goes to the base register's value taken at start, and each following access is 4 bytes higher. On a load, register r receives the memory word at its access address; registers that are not selected keep their value.
- R2: An all-zero mask transfers register 15 alone, in a single access at the base address. It still advances the base by 16 × 4 = 64 bytes.
- R3: The base register ends up holding its start value plus 4 times the transfer count. On a load this value replaces any word loaded into the base register.
- R4: When register 15 is stored, the word written is its current value plus INSTR_LEN (default 2).
- R5: On a store, a base register that is selected but is not the lowest selected index is written as the final advanced base. If it is the lowest selected index, its start value is written. A store never writes the register file before the writeback.
- R6: `flush_o` is high for exactly one cycle, in the completion cycle, only on a load whose effective mask includes register 15.
- R7: Each access holds `mem_req_o`, `mem_addr_o`, `mem_we_o` and the store data until `mem_ready_i` is high at a clock edge. The sequencer moves on to the next register only after that edge.
- R8: A start pulse that arrives while `busy_o` is high is ignored. It does not change the operation in progress and does not start another.
- R9: `busy_o` rises in the cycle after an accepted start. `done_o` is high for exactly one cycle, the cycle in which the base writeback is presented.
- R10: After reset, `busy_o`, `done_o`, `flush_o`, `mem_req_o` and `rf_we_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only when idle |
| is_load_i | input | 1 | 1 = load from memory, 0 = store to memory |
| base_idx_i | input | 4 | Index of the base register |
| mask_i | input | 16 | Register selection mask, bit r selects register r |
| rf_raddr_o | output | 4 | Register-file read index |
| rf_rdata_i | input | 32 | Register-file read data (combinational) |
| rf_we_o | output | 1 | Register-file write enable |
| rf_waddr_o | output | 4 | Register-file write index |
| rf_wdata_o | output | 32 | Register-file write data |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write (store) when high |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, valid with ready |
| mem_ready_i | input | 1 | Memory access complete |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| flush_o | output | 1 | One-cycle pipeline-flush pulse |

## Verification
The hardest situation to reach is a base register that appears inside its own mask. The stored word then depends on whether the base is the lowest selected index, and a loaded word is then overwritten by the writeback. The stimulus table places the base below, inside and at the start of the mask, for both directions and for the full mask. Stalled memory responses of up to two extra cycles stretch each handshake, so that the hold rule is observed on every access. A directed run fires a second, different start pulse while a stalled transfer is in flight, then waits long enough that any second operation would show up as an extra done pulse.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_XFER = 2'd1,
      ST_WB   = 2'd2
   } xfer_state_e;

endpackage

// File: rtl/blkxfer_lowbit.sv
// Index of the lowest set bit of a vector (0 when the vector is empty).
module blkxfer_lowbit #(
   parameter int N  = 16,
   parameter int IW = $clog2(N)
) (
   input  logic [N-1:0]  vec_i,
   output logic [IW-1:0] idx_o
);

   always_comb begin
      idx_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec_i[i]) idx_o = IW'(i);
      end
   end

endmodule

// File: rtl/blkxfer_popcnt.sv
// Number of set bits in a vector.
module blkxfer_popcnt #(
   parameter int N  = 16,
   parameter int CW = $clog2(N + 1)
) (
   input  logic [N-1:0]  vec_i,
   output logic [CW-1:0] cnt_o
);

   always_comb begin
      cnt_o = '0;
      for (int i = 0; i < N; i++) begin
         cnt_o = cnt_o + CW'(vec_i[i]);
      end
   end

endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
   import blkxfer_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int NREG      = 16,
   parameter int ADDR_STEP = 4,
   parameter int INSTR_LEN = 2,
   localparam int IDX_W    = $clog2(NREG),
   localparam int CNT_W    = $clog2(NREG + 1),
   localparam int PC_IDX   = NREG - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              is_load_i,
   input  logic [IDX_W-1:0]  base_idx_i,
   input  logic [NREG-1:0]   mask_i,
   output logic [IDX_W-1:0]  rf_raddr_o,
   input  logic [DATA_W-1:0] rf_rdata_i,
   output logic              rf_we_o,
   output logic [IDX_W-1:0]  rf_waddr_o,
   output logic [DATA_W-1:0] rf_wdata_o,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic [DATA_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   input  logic [DATA_W-1:0] mem_rdata_i,
   input  logic              mem_ready_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              flush_o
);

   // elaboration-time parameter checks
   generate
      if (NREG < 2 || (NREG & (NREG - 1)) != 0) begin : g_bad_nreg
         $error("blkxfer_seq: NREG must be a power of two >= 2");
      end
      if (ADDR_STEP < 1) begin : g_bad_step
         $error("blkxfer_seq: ADDR_STEP must be positive");
      end
      if (INSTR_LEN < 0 || DATA_W < 8) begin : g_bad_width
         $error("blkxfer_seq: INSTR_LEN/DATA_W out of range");
      end
   endgenerate

   xfer_state_e         state_q;
   logic                ld_q;
   logic [IDX_W-1:0]    base_q;
   logic [DATA_W-1:0]   base_val_q;
   logic [NREG-1:0]     left_q;
   logic [CNT_W-1:0]    cnt_q;
   logic [DATA_W-1:0]   addr_q;
   logic                first_q;
   logic                pc_hit_q;

   logic [NREG-1:0]     eff_mask;
   logic [CNT_W-1:0]    pop_cnt;
   logic [CNT_W-1:0]    eff_cnt;
   logic [IDX_W-1:0]    cur_idx;
   logic [NREG-1:0]     left_nxt;
   logic [DATA_W-1:0]   wb_val;
   logic                in_xfer;
   logic                in_wb;

   // empty mask degenerates to the program counter alone, counted as full
   assign eff_mask = (mask_i == '0) ? (NREG'(1) << PC_IDX) : mask_i;
   assign eff_cnt  = (mask_i == '0) ? CNT_W'(NREG) : pop_cnt;

   blkxfer_popcnt #(.N(NREG), .CW(CNT_W)) pop_i (
      .vec_i (mask_i),
      .cnt_o (pop_cnt)
   );

   blkxfer_lowbit #(.N(NREG), .IW(IDX_W)) low_i (
      .vec_i (left_q),
      .idx_o (cur_idx)
   );

   assign left_nxt = left_q & ~(NREG'(1) << cur_idx);
   assign wb_val   = base_val_q + DATA_W'(cnt_q) * DATA_W'(ADDR_STEP);
   assign in_xfer  = (state_q == ST_XFER);
   assign in_wb    = (state_q == ST_WB);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         ld_q       <= 1'b0;
         base_q     <= '0;
         base_val_q <= '0;
         left_q     <= '0;
         cnt_q      <= '0;
         addr_q     <= '0;
         first_q    <= 1'b0;
         pc_hit_q   <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  state_q    <= ST_XFER;
                  ld_q       <= is_load_i;
                  base_q     <= base_idx_i;
                  base_val_q <= rf_rdata_i;
                  addr_q     <= rf_rdata_i;
                  left_q     <= eff_mask;
                  cnt_q      <= eff_cnt;
                  first_q    <= 1'b1;
                  pc_hit_q   <= eff_mask[PC_IDX];
               end
            end
            ST_XFER: begin
               if (mem_ready_i) begin
                  left_q  <= left_nxt;
                  addr_q  <= addr_q + DATA_W'(ADDR_STEP);
                  first_q <= 1'b0;
                  if (left_nxt == '0) state_q <= ST_WB;
               end
            end
            ST_WB:   state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // register-file ports: idle reads the base, transfers read the current index
   assign rf_raddr_o = in_xfer ? cur_idx : base_idx_i;
   assign rf_we_o    = (in_xfer && ld_q && mem_ready_i) || in_wb;
   assign rf_waddr_o = in_wb ? base_q : cur_idx;
   assign rf_wdata_o = in_wb ? wb_val : mem_rdata_i;

   // memory side
   assign mem_req_o  = in_xfer;
   assign mem_we_o   = in_xfer && !ld_q;
   assign mem_addr_o = addr_q;

   always_comb begin
      if (cur_idx == base_q && !first_q)
         mem_wdata_o = wb_val;
      else if (cur_idx == IDX_W'(PC_IDX))
         mem_wdata_o = rf_rdata_i + DATA_W'(INSTR_LEN);
      else
         mem_wdata_o = rf_rdata_i;
   end

   assign busy_o  = (state_q != ST_IDLE);
   assign done_o  = in_wb;
   assign flush_o = in_wb && ld_q && pc_hit_q;

   // R9
   done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R7
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_ready_i) |=>
         (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(rf_raddr_o)));

   // R1
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && mem_ready_i) |=>
         (!mem_req_o || mem_addr_o == $past(mem_addr_o) + DATA_W'(ADDR_STEP)));

   // R6
   flush_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_o |-> done_o);

   // R8
   busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(start_i));

   // R5
   store_no_rf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && mem_we_o) |-> !rf_we_o);

endmodule

// File: tb/blkxfer_seq_tb_top.sv
module blkxfer_seq_tb_top;

   localparam int DW = 32;
   localparam int NR = 16;
   localparam int IW = 4;
   localparam int ILEN = 2;
   localparam logic [DW-1:0] BASE0 = 32'h0000_0040;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          is_load = 1'b0;
   logic [IW-1:0] base_idx = '0;
   logic [NR-1:0] mask = '0;
   logic [IW-1:0] rf_raddr, rf_waddr;
   logic [DW-1:0] rf_rdata, rf_wdata;
   logic          rf_we;
   logic          mem_req, mem_we;
   logic [DW-1:0] mem_addr, mem_wdata, mem_rdata;
   logic          mem_ready = 1'b0;
   logic          busy, done, flush;

   logic [DW-1:0] regs [NR];
   logic [DW-1:0] mem  [64];

   assign rf_rdata  = regs[rf_raddr];
   assign mem_rdata = mem[mem_addr[7:2]];

   blkxfer_seq dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start), .is_load_i(is_load),
      .base_idx_i(base_idx), .mask_i(mask),
      .rf_raddr_o(rf_raddr), .rf_rdata_i(rf_rdata), .rf_we_o(rf_we),
      .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata),
      .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
      .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ready_i(mem_ready),
      .busy_o(busy), .done_o(done), .flush_o(flush)
   );

   int n_checks = 0;
   int n_errors = 0;

   // memory and register-file model state
   int            lat = 0;
   int            wcnt = 0;
   int            nxfer = 0;
   int            ndone = 0;
   int            nflush = 0;
   int            hold_err = 0;
   bit            seen = 1'b0;
   logic [DW-1:0] hold_addr = '0;
   logic [DW-1:0] log_addr [NR];
   logic [DW-1:0] log_data [NR];

   // stimulus table: {load, base[3:0], mask[15:0], latency[1:0]}
   localparam int NVEC = 10;
   localparam logic [22:0] VEC [NVEC] = '{
      {1'b0, 4'd2, 16'h00F0, 2'd0},   // R1 store, base outside mask
      {1'b1, 4'd1, 16'h0A0C, 2'd1},   // R1 load, stalled
      {1'b0, 4'd3, 16'h000A, 2'd0},   // R5 base stored second
      {1'b0, 4'd4, 16'h0030, 2'd2},   // R5 base stored first
      {1'b1, 4'd5, 16'h8021, 2'd0},   // R3 R6 base loaded, pc loaded
      {1'b0, 4'd0, 16'h8001, 2'd1},   // R4 pc stored
      {1'b1, 4'd7, 16'h0000, 2'd0},   // R2 empty load
      {1'b0, 4'd6, 16'h0000, 2'd1},   // R2 R4 empty store
      {1'b1, 4'd2, 16'hFFFF, 2'd2},   // R3 full load
      {1'b0, 4'd9, 16'hFFFF, 2'd0}    // R5 full store
   };

   task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                      input logic [DW-1:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   endtask

   // memory responder and register-file write port
   initial begin
      forever begin
         @(negedge clk);
         if (mem_ready) begin
            mem_ready = 1'b0;
            wcnt = 0;
            seen = 1'b0;
         end
         if (mem_req) begin
            if (!seen) begin
               seen = 1'b1;
               hold_addr = mem_addr;
            end else if (mem_addr != hold_addr) begin
               hold_err++;
            end
            if (wcnt >= lat) begin
               mem_ready = 1'b1;
               if (nxfer < NR) begin
                  log_addr[nxfer] = mem_addr;
                  log_data[nxfer] = mem_wdata;
               end
               nxfer++;
               if (mem_we) mem[mem_addr[7:2]] = mem_wdata;
            end else begin
               wcnt++;
            end
         end
         #1;
         if (rf_we) regs[rf_waddr] = rf_wdata;
         if (done) ndone++;
         if (flush) nflush++;
      end
   end

   task automatic run_op(input bit ld, input logic [IW-1:0] b, input logic [NR-1:0] m,
                         input int l, input bit spur);
      logic [DW-1:0] r0 [NR];
      logic [DW-1:0] m0 [64];
      logic [DW-1:0] er [NR];
      logic [NR-1:0] em;
      int            ecnt;
      int            k;
      int            guard;
      logic [DW-1:0] wbv;
      logic [DW-1:0] ea;
      logic [DW-1:0] ed;
      for (int i = 0; i < NR; i++) regs[i] = 32'hA500_0000 | (i << 8) | i;
      regs[b] = BASE0;
      for (int j = 0; j < 64; j++) mem[j] = 32'hC0DE_0000 + j;
      for (int i = 0; i < NR; i++) r0[i] = regs[i];
      for (int j = 0; j < 64; j++) m0[j] = mem[j];
      lat = l; nxfer = 0; ndone = 0; nflush = 0; hold_err = 0;

      @(negedge clk);
      #2;
      start = 1'b1; is_load = ld; base_idx = b; mask = m;
      @(negedge clk);
      #2;
      start = 1'b0;
      // R9 busy follows an accepted start
      chk(busy == 1'b1, "R9 busy after start", {31'd0, busy}, 32'd1);
      if (spur) begin
         @(negedge clk);
         #2;
         // R8 second start while busy, different operation
         start = 1'b1; is_load = ~ld; base_idx = b + 4'd1; mask = 16'h0F0F;
         @(negedge clk);
         #2;
         start = 1'b0;
      end
      guard = 0;
      while (ndone == 0 && guard < 500) begin
         @(negedge clk);
         #2;
         guard++;
      end
      repeat (40) @(negedge clk);
      #2;

      em   = (m == '0) ? 16'h8000 : m;
      ecnt = (m == '0) ? 16 : $countones(m);
      wbv  = BASE0 + 32'(ecnt) * 32'd4;
      for (int i = 0; i < NR; i++) er[i] = r0[i];
      k = 0;
      for (int r = 0; r < NR; r++) begin
         if (em[r]) begin
            ea = BASE0 + 32'(k) * 32'd4;
            if (k < NR) chk(log_addr[k] == ea, "R1 access address", log_addr[k], ea);
            if (ld) begin
               er[r] = m0[ea[7:2]];
            end else begin
               if (r == int'(b) && k != 0) begin
                  ed = wbv;
                  chk(log_data[k] == ed, "R5 base stored late", log_data[k], ed);
               end else if (r == NR - 1) begin
                  ed = r0[r] + 32'(ILEN);
                  chk(log_data[k] == ed, "R4 stored pc", log_data[k], ed);
               end else begin
                  ed = r0[r];
                  if (r == int'(b))
                     chk(log_data[k] == ed, "R5 base stored first", log_data[k], ed);
                  else
                     chk(log_data[k] == ed, "R1 store data", log_data[k], ed);
               end
               chk(mem[ea[7:2]] == ed, "R1 memory word", mem[ea[7:2]], ed);
            end
            k++;
         end
      end
      er[b] = wbv;
      chk(regs[b] == wbv, "R3 base writeback", regs[b], wbv);
      for (int i = 0; i < NR; i++) begin
         if (i != int'(b))
            chk(regs[i] == er[i], "R1 register contents", regs[i], er[i]);
      end
      if (m == '0)
         chk(nxfer == 1, "R2 single access for empty mask", 32'(nxfer), 32'd1);
      else
         chk(nxfer == ecnt, "R1 access count", 32'(nxfer), 32'(ecnt));
      chk(ndone == 1, spur ? "R8 one operation only" : "R9 single done",
          32'(ndone), 32'd1);
      chk(nflush == ((ld && em[15]) ? 1 : 0), "R6 flush pulses", 32'(nflush),
          (ld && em[15]) ? 32'd1 : 32'd0);
      chk(hold_err == 0, "R7 request held until ready", 32'(hold_err), 32'd0);
      chk(busy == 1'b0, "R9 idle after done", {31'd0, busy}, 32'd0);
   endtask

   initial begin
      #(200000 * 10);
      n_errors++;
      n_checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      for (int i = 0; i < NR; i++) regs[i] = '0;
      for (int j = 0; j < 64; j++) mem[j] = '0;
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(busy == 1'b0, "R10 busy in reset", {31'd0, busy}, 32'd0);
      chk(done == 1'b0 && flush == 1'b0, "R10 done/flush in reset",
          {30'd0, done, flush}, 32'd0);
      chk(mem_req == 1'b0 && rf_we == 1'b0, "R10 req/we in reset",
          {30'd0, mem_req, rf_we}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      #2;
      chk(busy == 1'b0 && mem_req == 1'b0, "R10 idle after reset",
          {30'd0, busy, mem_req}, 32'd0);

      for (int v = 0; v < NVEC; v++) begin
         run_op(VEC[v][22], VEC[v][21:18], VEC[v][17:2], int'(VEC[v][1:0]), 1'b0);
      end

      // R8 directed: spurious start during a stalled store, then a stalled load
      run_op(1'b0, 4'd3, 16'h0F38, 3, 1'b1);
      run_op(1'b1, 4'd0, 16'h80F0, 3, 1'b1);
      // R7 long stalls with base inside the mask
      run_op(1'b1, 4'd8, 16'h0300, 3, 1'b0);
      finish_run();
   end

endmodule